// File: doc/BRIEF.md
# Clock Frequency Monitor Unit

This block watches the health of two clocks using a trusted on-chip RC clock as the timebase, and can measure a third, selectable clock. The RC reference clock is the block's main clock. An oscillator supervisor counts oscillator cycles over a fixed window of reference cycles and raises a fault if the oscillator runs slower than the reference divided by a programmable power of two. A window supervisor divides the monitored clock by four, counts the divided edges over the same window, and flags a result above a high limit or below a low limit. It also flags loss of clock when no divided edge arrives within a timeout.

A frequency meter reverses the roles. The oscillator clock times the measurement window, and one of three metered clocks is counted. The metered clocks are the RC reference and two external clocks, each divided by eight in its own domain. A start pulse begins a measurement. When the window closes, the result is latched and a done flag is raised. Every crossing between clock domains uses two-flop synchronizers on toggle or divided-clock levels. No counter is sampled across a domain boundary while it is changing.

All fault flags are sticky. They clear by write-one-to-clear, and a new detection in the same cycle as a clear takes precedence. The limits are only valid when every supervised toggle rate stays well below half the rate of the clock that samples it.

Top module: `clk_freq_mon`

## Requirements
- R1: Over each window of WIN reference cycles, the oscillator cycle count is compared with WIN >> rc_div_i. A count strictly below that limit sets flags_o[0] (oscillator slow) while osc_en_i is 1.
- R2: The monitored clock is divided by 4. If the divided rising-edge count over a window exceeds hi_ref_i, flags_o[2] (frequency high) is set.
- R3: If the divided monitored count over a window is below lo_ref_i, flags_o[3] (frequency low) is set.
- R4: flags_o[1] (clock lost) is set when no divided monitored edge is seen for TMO consecutive reference cycles.
- R5: Flags are sticky. A 1 in flag_clr_i clears the matching flag, but a detection in the same cycle as the clear wins.
- R6: While mon_en_i is 0, flags_o[3:1] are 0 from the next cycle on. While osc_en_i is 0, flags_o[0] is 0 from the next cycle on.
- R7: Meter select mtr_sel_i: 2'b01 picks metered clock 1, 2'b10 picks metered clock 2, and 2'b00 or 2'b11 picks the RC reference.
- R8: A pulse on mtr_start_i clears mtr_done_o in the next cycle. The meter then counts rising edges of the selected clock divided by 8 over mtr_win_i oscillator cycles, loads the count into mtr_val_o and sets mtr_done_o. mtr_val_o changes only as mtr_done_o is set.
- R9: After reset, flags_o, mtr_val_o and mtr_done_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | RC reference clock, main clock |
| rst_ni | input | 1 | Active-low asynchronous reset, all domains |
| osc_clk_i | input | 1 | Oscillator clock, supervised and meter timebase |
| mon_clk_i | input | 1 | Monitored clock for the window check |
| mt1_clk_i | input | 1 | Metered clock 1 |
| mt2_clk_i | input | 1 | Metered clock 2 |
| osc_en_i | input | 1 | Oscillator supervisor enable |
| mon_en_i | input | 1 | Window and loss supervisor enable |
| rc_div_i | input | RDW | Power-of-two divider exponent for the oscillator limit |
| hi_ref_i | input | CW | Upper limit in divided-edge counts per window |
| lo_ref_i | input | CW | Lower limit in divided-edge counts per window |
| mtr_sel_i | input | 2 | Metered clock select |
| mtr_win_i | input | MWW | Meter window in oscillator cycles |
| mtr_start_i | input | 1 | Meter start pulse |
| flag_clr_i | input | 4 | Write-one-to-clear per flag |
| flags_o | output | 4 | Sticky flags: [0] osc slow, [1] lost, [2] high, [3] low |
| mtr_val_o | output | MCW | Last meter result |
| mtr_done_o | output | 1 | Meter result valid |

## Verification
A write-one-to-clear and a fresh fault detection can land on the same flag in the same reference cycle. To provoke this, the bench stops the monitored clock until the loss timeout is saturated, so the loss condition holds in every cycle, and then holds the clear bit for that flag high for several cycles. The flag must read 1 throughout. Once the clock runs again, a single clear must drop it to 0. A start pulse arriving in the same cycle as a meter completion is covered by an assertion: mtr_val_o may change only when mtr_done_o rises.

// File: rtl/cfm_pkg.sv
`timescale 1ns/1ps
package cfm_pkg;
  localparam int NUM_FLAGS     = 4;
  localparam int FLG_OSC_SLOW  = 0;
  localparam int FLG_CLK_LOST  = 1;
  localparam int FLG_FREQ_HIGH = 2;
  localparam int FLG_FREQ_LOW  = 3;

  typedef enum logic [1:0] {
    SEL_REF_A = 2'b00,
    SEL_MT1   = 2'b01,
    SEL_MT2   = 2'b10,
    SEL_REF_B = 2'b11
  } mtr_sel_e;
endpackage

// File: rtl/cfm_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer plus edge detect; RISE=1 rising edge, RISE=0 any change
module cfm_sync #(
  parameter bit RISE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic edge_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], d_i};
  end

  generate
    if (RISE) begin : g_rise
      assign edge_o = sh_q[1] & ~sh_q[2];
    end else begin : g_chg
      assign edge_o = sh_q[1] ^ sh_q[2];
    end
  endgenerate
endmodule

// File: rtl/cfm_prescale.sv
`timescale 1ns/1ps
module cfm_prescale #(
  parameter int LOG2 = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic div_o
);
  logic [LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign div_o = cnt_q[LOG2-1];
endmodule

// File: rtl/cfm_meter.sv
`timescale 1ns/1ps
// Oscillator-domain meter core
module cfm_meter #(
  parameter int MWW = 12,
  parameter int MCW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           src_i,
  input  logic           start_tgl_i,
  input  logic [MWW-1:0] win_i,
  output logic [MCW-1:0] val_o,
  output logic           done_tgl_o
);
  logic           start_chg, src_rise, busy_q, last_cyc;
  logic [MWW-1:0] win_cnt_q;
  logic [MCW-1:0] cnt_q, cnt_nxt;

  cfm_sync #(.RISE(1'b0)) u_start_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(start_tgl_i), .edge_o(start_chg));
  cfm_sync #(.RISE(1'b1)) u_src_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(src_i), .edge_o(src_rise));

  assign cnt_nxt  = cnt_q + MCW'(src_rise);
  // zero window behaves as one cycle
  assign last_cyc = (MWW'(win_cnt_q + 1'b1) >= win_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      win_cnt_q  <= '0;
      cnt_q      <= '0;
      val_o      <= '0;
      done_tgl_o <= 1'b0;
    end else if (start_chg) begin
      busy_q    <= 1'b1;
      win_cnt_q <= '0;
      cnt_q     <= '0;
    end else if (busy_q) begin
      if (last_cyc) begin
        val_o      <= cnt_nxt;
        busy_q     <= 1'b0;
        done_tgl_o <= ~done_tgl_o;
      end else begin
        win_cnt_q <= win_cnt_q + 1'b1;
        cnt_q     <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/clk_freq_mon.sv
`timescale 1ns/1ps
module clk_freq_mon #(
  parameter int WIN     = 64,
  parameter int TMO     = 32,
  parameter int RDW     = 3,
  parameter int MWW     = 12,
  parameter int MCW     = 16,
  parameter int MTR_PRE = 3,
  localparam int WIN_W  = $clog2(WIN),
  localparam int CW     = $clog2(WIN) + 1,
  localparam int TMO_W  = $clog2(TMO + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           osc_clk_i,
  input  logic           mon_clk_i,
  input  logic           mt1_clk_i,
  input  logic           mt2_clk_i,
  input  logic           osc_en_i,
  input  logic           mon_en_i,
  input  logic [RDW-1:0] rc_div_i,
  input  logic [CW-1:0]  hi_ref_i,
  input  logic [CW-1:0]  lo_ref_i,
  input  logic [1:0]     mtr_sel_i,
  input  logic [MWW-1:0] mtr_win_i,
  input  logic           mtr_start_i,
  input  logic [3:0]     flag_clr_i,
  output logic [3:0]     flags_o,
  output logic [MCW-1:0] mtr_val_o,
  output logic           mtr_done_o
);
  import cfm_pkg::*;

  // ---------------- source-domain dividers ----------------
  logic osc_tgl, mon_div;
  logic [2:0] mt_clk, mt_div;
  logic mt_sel_div;

  cfm_prescale #(.LOG2(1)) u_osc_tgl (.clk_i(osc_clk_i), .rst_ni(rst_ni), .div_o(osc_tgl));
  cfm_prescale #(.LOG2(2)) u_mon_pre (.clk_i(mon_clk_i), .rst_ni(rst_ni), .div_o(mon_div));

  assign mt_clk = {mt2_clk_i, mt1_clk_i, clk_i};
  for (genvar g = 0; g < 3; g++) begin : g_mt_pre
    cfm_prescale #(.LOG2(MTR_PRE)) u_pre (.clk_i(mt_clk[g]), .rst_ni(rst_ni), .div_o(mt_div[g]));
  end

  always_comb begin
    unique case (mtr_sel_e'(mtr_sel_i))
      SEL_MT1: mt_sel_div = mt_div[1];
      SEL_MT2: mt_sel_div = mt_div[2];
      default: mt_sel_div = mt_div[0];
    endcase
  end

  // ---------------- supervisors, reference domain ----------------
  logic osc_chg, mon_rise, win_end;
  logic [WIN_W-1:0] win_cnt_q;
  logic [CW-1:0]    osc_cnt_q, mon_cnt_q, osc_sum, mon_sum, osc_lim;
  logic [TMO_W-1:0] tmo_cnt_q;
  logic [3:0]       set_v, en_mask, flags_q;

  cfm_sync #(.RISE(1'b0)) u_osc_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(osc_tgl), .edge_o(osc_chg));
  cfm_sync #(.RISE(1'b1)) u_mon_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(mon_div), .edge_o(mon_rise));

  assign win_end = (win_cnt_q == WIN_W'(WIN - 1));
  assign osc_sum = osc_cnt_q + CW'(osc_chg);
  assign mon_sum = mon_cnt_q + CW'(mon_rise);
  assign osc_lim = CW'(WIN) >> rc_div_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt_q <= '0;
      osc_cnt_q <= '0;
      mon_cnt_q <= '0;
    end else if (win_end) begin
      win_cnt_q <= '0;
      osc_cnt_q <= '0;
      mon_cnt_q <= '0;
    end else begin
      win_cnt_q <= win_cnt_q + 1'b1;
      osc_cnt_q <= osc_sum;
      mon_cnt_q <= mon_sum;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              tmo_cnt_q <= '0;
    else if (mon_rise || !mon_en_i)           tmo_cnt_q <= '0;
    else if (tmo_cnt_q != TMO_W'(TMO))        tmo_cnt_q <= tmo_cnt_q + 1'b1;
  end

  always_comb begin
    set_v                = '0;
    set_v[FLG_OSC_SLOW]  = win_end && (osc_sum < osc_lim);
    set_v[FLG_CLK_LOST]  = (tmo_cnt_q == TMO_W'(TMO));
    set_v[FLG_FREQ_HIGH] = win_end && (mon_sum > hi_ref_i);
    set_v[FLG_FREQ_LOW]  = win_end && (mon_sum < lo_ref_i);
  end

  assign en_mask = {mon_en_i, mon_en_i, mon_en_i, osc_en_i};

  // detection wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= ((flags_q & ~flag_clr_i) | set_v) & en_mask;
  end
  assign flags_o = flags_q;

  // ---------------- meter ----------------
  logic           start_tgl_q, done_tgl, done_chg;
  logic [MCW-1:0] osc_val;

  cfm_meter #(.MWW(MWW), .MCW(MCW)) u_meter (
    .clk_i(osc_clk_i), .rst_ni(rst_ni), .src_i(mt_sel_div), .start_tgl_i(start_tgl_q),
    .win_i(mtr_win_i), .val_o(osc_val), .done_tgl_o(done_tgl));

  cfm_sync #(.RISE(1'b0)) u_done_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(done_tgl), .edge_o(done_chg));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_tgl_q <= 1'b0;
      mtr_done_o  <= 1'b0;
      mtr_val_o   <= '0;
    end else if (mtr_start_i) begin
      start_tgl_q <= ~start_tgl_q;
      mtr_done_o  <= 1'b0;
    end else if (done_chg) begin
      mtr_val_o  <= osc_val;  // held stable in source domain before toggle
      mtr_done_o <= 1'b1;
    end
  end
endmodule

// File: rtl/clk_freq_mon_chk.sv
`timescale 1ns/1ps
module clk_freq_mon_chk #(
  parameter int MCW = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           osc_en_i,
  input logic           mon_en_i,
  input logic           mtr_start_i,
  input logic [3:0]     flag_clr_i,
  input logic [3:0]     flags_o,
  input logic [MCW-1:0] mtr_val_o,
  input logic           mtr_done_o
);
  logic [3:0] keep;
  assign keep = flags_o & ~flag_clr_i & {mon_en_i, mon_en_i, mon_en_i, osc_en_i};

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_o & $past(keep)) == $past(keep)));

  a_r6_mon_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mon_en_i |=> (flags_o[3:1] == 3'b000));

  a_r6_osc_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> !flags_o[0]);

  a_r8_start_drops_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mtr_start_i |=> !mtr_done_o);

  a_r8_val_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mtr_done_o |-> $stable(mtr_val_o));
endmodule

bind clk_freq_mon clk_freq_mon_chk #(.MCW(MCW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .osc_en_i(osc_en_i), .mon_en_i(mon_en_i),
  .mtr_start_i(mtr_start_i), .flag_clr_i(flag_clr_i), .flags_o(flags_o),
  .mtr_val_o(mtr_val_o), .mtr_done_o(mtr_done_o));

// File: tb/sim_clk_freq_mon.sv
`timescale 1ns/1ps
module sim_clk_freq_mon;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 64;
  localparam int CW  = 7;
  localparam int MCW = 16;
  localparam int MWW = 12;
  localparam int OSC_PERIOD = 25;
  localparam int MT_WIN = 100;

  typedef struct packed {
    logic [7:0] half;
    logic [2:0] rdiv;
    logic [3:0] exp;
  } vec_t;

  // osc 25 ns -> ~25 counts/window; hi=20, lo=5; mon divided by 4
  localparam vec_t VECS [6] = '{
    '{half: 8'd10, rdiv: 3'd2, exp: 4'b0000},
    '{half: 8'd3,  rdiv: 3'd2, exp: 4'b0100},
    '{half: 8'd25, rdiv: 3'd2, exp: 4'b1000},
    '{half: 8'd10, rdiv: 3'd1, exp: 4'b0001},
    '{half: 8'd10, rdiv: 3'd0, exp: 4'b0001},
    '{half: 8'd10, rdiv: 3'd3, exp: 4'b0000}
  };

  logic clk = 0, osc_clk = 0, mon_clk = 0, mt1_clk = 0, mt2_clk = 0;
  logic rst_n = 0;
  logic osc_en = 1, mon_en = 1;
  logic [2:0] rc_div = 3'd2;
  logic [CW-1:0] hi_ref = 7'd20, lo_ref = 7'd5;
  logic [1:0] mtr_sel = 2'b00;
  logic [MWW-1:0] mtr_win = MWW'(MT_WIN);
  logic mtr_start = 0;
  logic [3:0] flag_clr = 0;
  logic [3:0] flags;
  logic [MCW-1:0] mtr_val;
  logic mtr_done;
  int mon_half = 10;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always #12.5 osc_clk = ~osc_clk;
  always #8 mt1_clk = ~mt1_clk;
  always #16 mt2_clk = ~mt2_clk;
  always begin
    if (mon_half == 0) #1;
    else begin
      #(mon_half);
      mon_clk = ~mon_clk;
    end
  end

  clk_freq_mon u0 (
    .clk_i(clk), .rst_ni(rst_n), .osc_clk_i(osc_clk), .mon_clk_i(mon_clk),
    .mt1_clk_i(mt1_clk), .mt2_clk_i(mt2_clk), .osc_en_i(osc_en), .mon_en_i(mon_en),
    .rc_div_i(rc_div), .hi_ref_i(hi_ref), .lo_ref_i(lo_ref), .mtr_sel_i(mtr_sel),
    .mtr_win_i(mtr_win), .mtr_start_i(mtr_start), .flag_clr_i(flag_clr),
    .flags_o(flags), .mtr_val_o(mtr_val), .mtr_done_o(mtr_done));

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string req_of(logic [3:0] e);
    if (e[0])      return "R1";
    else if (e[2]) return "R2";
    else if (e[3]) return "R3";
    else           return "R1/R2/R3 none";
  endfunction

  task automatic clear_all();
    flag_clr = 4'hF;
    idle(1);
    flag_clr = 4'h0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic meter(logic [1:0] sel, int exp, string req);
    int waited = 0;
    mtr_sel = sel;
    idle(2);
    mtr_start = 1;
    idle(1);
    mtr_start = 0;
    chk(mtr_done == 1'b0, "R8 done cleared by start", int'(mtr_done), 0);
    while (!mtr_done && waited < 2000) begin
      idle(1);
      waited++;
    end
    chk(mtr_done == 1'b1, "R8 done set", int'(mtr_done), 1);
    chk((int'(mtr_val) >= exp - 2) && (int'(mtr_val) <= exp + 2), req, int'(mtr_val), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    idle(5);
    // R9 reset state
    chk(flags == 4'b0, "R9 flags", int'(flags), 0);
    chk(mtr_done == 1'b0, "R9 done", int'(mtr_done), 0);
    chk(mtr_val == '0, "R9 value", int'(mtr_val), 0);
    rst_n = 1;

    foreach (VECS[i]) begin
      mon_half = int'(VECS[i].half);
      rc_div   = VECS[i].rdiv;
      idle(3 * WIN);
      clear_all();
      idle(2 * WIN + 4);
      chk(flags == VECS[i].exp, req_of(VECS[i].exp), int'(flags), int'(VECS[i].exp));
    end

    // R4 loss of clock, R3 low count with stopped clock
    rc_div = 3'd2; mon_half = 10;
    idle(2 * WIN); clear_all();
    mon_half = 0;
    idle(2 * WIN);
    chk(flags[1] == 1'b1, "R4 clock lost", int'(flags[1]), 1);
    chk(flags[3] == 1'b1, "R3 stopped clock low", int'(flags[3]), 1);

    // R5 clear held while loss persists: detection wins
    flag_clr = 4'b0010;
    for (int k = 0; k < 5; k++) begin
      idle(1);
      chk(flags[1] == 1'b1, "R5 set beats clear", int'(flags[1]), 1);
    end
    flag_clr = 4'b0000;

    // R5 sticky after cause removed, then cleared
    mon_half = 10;
    idle(3 * WIN);
    chk(flags[1] == 1'b1, "R5 sticky", int'(flags[1]), 1);
    clear_all();
    idle(1);
    chk(flags == 4'b0, "R5 w1c", int'(flags), 0);

    // R6 disabled supervisors hold flags at 0
    mon_en = 0; mon_half = 0;
    idle(3 * WIN);
    chk(flags[3:1] == 3'b0, "R6 mon disabled", int'(flags[3:1]), 0);
    mon_half = 10;
    idle(2 * WIN);
    mon_en = 1;
    rc_div = 3'd0; osc_en = 0;
    idle(3 * WIN);
    chk(flags[0] == 1'b0, "R6 osc disabled", int'(flags[0]), 0);
    osc_en = 1;
    idle(2 * WIN + 4);
    chk(flags[0] == 1'b1, "R1 osc slow after enable", int'(flags[0]), 1);
    rc_div = 3'd2;
    idle(2 * WIN); clear_all();

    // R7/R8 meter: window 100 osc cycles = 2500 ns, counted clock divided by 8
    meter(2'b00, (MT_WIN * OSC_PERIOD) / (8 * CLK_PERIOD), "R7 sel 00 reference");
    meter(2'b01, (MT_WIN * OSC_PERIOD) / (8 * 16), "R7 sel 01 mt1");
    meter(2'b10, (MT_WIN * OSC_PERIOD) / (8 * 32), "R7 sel 10 mt2");
    meter(2'b11, (MT_WIN * OSC_PERIOD) / (8 * CLK_PERIOD), "R7 sel 11 reference");

    summary();
    $finish;
  end
endmodule